// File: doc/BRIEF.md
# Indirect Register Access Front End

This block gives a host access to a file of 8-bit controller registers through only two bus locations. Writing the address location sets a register pointer, and reading it returns a one-byte auxiliary status. The value location reads or writes whichever register the pointer selects. After each write through the value location the pointer steps to the next register. A run of neighbouring registers can therefore be loaded with one pointer write followed by several value writes.

Writes to the command register are decoded. There are three commands: a reset, a select-with-attention, and a transfer-info command. The transfer-info command loads a 24-bit byte count and then counts the bytes the host writes to the data register. A level interrupt output reports when a command has completed. The host clears it either by reading the command-status register or by writing the control register with its interrupt-clear bit set. The block has no bus phases toward targets, no DMA and no parity logic.

Top module: `ireg_frontend`

## Requirements
- R1: Only bus offset 3 (address port) and offset 7 (value port) are decoded. An access at any other offset changes no state, and a read there returns 0x00.
- R2: A write to the address port loads the register pointer with the written byte masked to NREGS-1.
- R3: A read of the address port returns a status byte. Bit 0 (buffer ready) is always 1, bit 7 equals the pending interrupt, and bits 6:1 are 0.
- R4: A value-port write stores the byte into the selected register and advances the pointer by one, wrapping from NREGS-1 to 0. A value-port read returns the selected register and leaves the pointer unchanged.
- R5: A value-port read of the command-status register (index 7) clears the pending interrupt. A value-port write to the control register (index 1) with bit 3 set also clears it.
- R6: Writing the command register (index 8) with code 0x00 in bits 6:0 sets the pending interrupt and loads the command-status register with 0x01. Bit 7 of the command byte is the single-byte flag and never affects decoding.
- R7: Command code 0x06 (select with attention) sets the pending interrupt. It loads the command-status register with 0x42 when target_present is low, and with 0x8A (phase change 0x88 with command phase 2) when target_present is high.
- R8: Command code 0x20 (transfer info) loads a 24-bit count from registers 12 (bits 23:16), 13 (bits 15:8) and 14 (bits 7:0). It zeroes the byte index and clears the pending interrupt.
- R9: While the command register holds code 0x20 and the index is below the count, each value-port write to the data register (index 9) advances the index. The write that makes the index reach the count sets the pending interrupt and loads the command-status register with 0x18 when dir_out is high (data-out phase 0), or 0x19 when it is low (data-in phase 1).
- R10: A data-register write when no transfer is active, or after the count is reached, does not advance the index and sets the sticky xfer_err output. Only a reset clears xfer_err.
- R11: After reset every register, the pointer, irq and xfer_err are zero. irq is a level output that equals the pending interrupt in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3 | Byte offset within the device window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read |
| target_present | input | 1 | A target answers the selection |
| dir_out | input | 1 | The next phase after a transfer is data out |
| irq | output | 1 | Level interrupt |
| xfer_err | output | 1 | Sticky misuse flag for the data register |

## Verification
The bench builds the block with NREGS = 32. A pointer byte of 0x25 therefore exercises the mask, and a write at index 31 exercises the wrap to 0. Transfers of 3 bytes and of 256 bytes run, so the middle count byte takes part in the count as well as the low byte. A reference model tracks the pending flag and the error flag and is compared with irq and xfer_err on every clock. Read-backs through the value port show whether a command wrote the command-status register correctly and whether an ignored data write left the index unchanged.

// File: rtl/ireg_frontend.sv
module ireg_frontend #(
  parameter int NREGS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_off,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       target_present,
  input  logic       dir_out,
  output logic       irq,
  output logic       xfer_err
);
  localparam int PTR_W = $clog2(NREGS);
  localparam int CNT_W = 24;
  localparam logic [PTR_W-1:0] I_CTRL   = PTR_W'(1);
  localparam logic [PTR_W-1:0] I_CSR    = PTR_W'(7);
  localparam logic [PTR_W-1:0] I_CMD    = PTR_W'(8);
  localparam logic [PTR_W-1:0] I_DATA   = PTR_W'(9);
  localparam int I_CNT_HI = 12;
  localparam int I_CNT_MD = 13;
  localparam int I_CNT_LO = 14;
  localparam int CLR_BIT = 3;
  localparam logic [6:0] C_RESET = 7'h00;
  localparam logic [6:0] C_SELA  = 7'h06;
  localparam logic [6:0] C_XFER  = 7'h20;
  localparam logic [2:0] PH_OUT = 3'd0;
  localparam logic [2:0] PH_IN  = 3'd1;
  localparam logic [2:0] PH_CMD = 3'd2;
  localparam logic [7:0] S_RESET = 8'h01;
  localparam logic [7:0] S_SELTO = 8'h42;
  localparam logic [7:0] S_PHREQ = 8'h88;
  localparam logic [7:0] S_XDONE = 8'h18;

  logic [7:0]       regs [NREGS];
  logic [PTR_W-1:0] ptr;
  logic             pend, err;
  logic [CNT_W-1:0] cnt, idx;

  wire acc_addr = bus_sel && (bus_off == 3'd3);
  wire acc_val  = bus_sel && (bus_off == 3'd7);
  wire wr_val   = acc_val && bus_wr;
  wire rd_val   = acc_val && !bus_wr;
  wire xfer_on  = (regs[I_CMD][6:0] == C_XFER);
  wire data_ok  = xfer_on && (idx < cnt);
  wire last     = (idx + CNT_W'(1)) == cnt;

  assign irq      = pend;
  assign xfer_err = err;

  always_comb begin
    if (acc_addr && !bus_wr)
      bus_rdata = {pend, 6'b0, 1'b1};
    else if (rd_val)
      bus_rdata = regs[ptr];
    else
      bus_rdata = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= 8'h00;
      ptr  <= '0;
      pend <= 1'b0;
      err  <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else begin
      if (acc_addr && bus_wr)
        ptr <= bus_wdata[PTR_W-1:0];
      if (rd_val && ptr == I_CSR)
        pend <= 1'b0;
      if (wr_val) begin
        regs[ptr] <= bus_wdata;
        ptr <= ptr + PTR_W'(1);
        if (ptr == I_CTRL && bus_wdata[CLR_BIT])
          pend <= 1'b0;
        if (ptr == I_CMD) begin
          case (bus_wdata[6:0])
            C_RESET: begin
              pend <= 1'b1;
              regs[I_CSR] <= S_RESET;
            end
            C_SELA: begin
              pend <= 1'b1;
              regs[I_CSR] <= target_present ? (S_PHREQ | {5'b0, PH_CMD}) : S_SELTO;
            end
            C_XFER: begin
              cnt  <= {regs[I_CNT_HI], regs[I_CNT_MD], regs[I_CNT_LO]};
              idx  <= '0;
              pend <= 1'b0;
            end
            default: ;
          endcase
        end
        if (ptr == I_DATA) begin
          if (data_ok) begin
            idx <= idx + CNT_W'(1);
            if (last) begin
              pend <= 1'b1;
              regs[I_CSR] <= S_XDONE | {5'b0, dir_out ? PH_OUT : PH_IN};
            end
          end else begin
            err <= 1'b1;
          end
        end
      end
    end
  end

  a_r3_status_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr && !bus_wr) |-> (bus_rdata[0] && bus_rdata[7] == irq));
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> ptr == $past(ptr) + PTR_W'(1));
  a_r4_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_val |=> $stable(ptr));
  a_r5_csr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_val && ptr == I_CSR) |=> !irq);
  a_r6_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && ptr == I_CMD && bus_wdata[6:0] == C_RESET) |=> (irq && regs[I_CSR] == S_RESET));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> xfer_err);
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (idx <= cnt) || !xfer_on);
endmodule

// File: tb/ireg_frontend_tb.sv
module ireg_frontend_tb_top;
  localparam int CLK_P = 10;
  localparam int NR = 32;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_off = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic target_present = 0, dir_out = 0;
  logic irq, xfer_err;

  ireg_frontend #(.NREGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .target_present(target_present), .dir_out(dir_out),
    .irq(irq), .xfer_err(xfer_err));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int mregs [NR];
  int mptr = 0, mpend = 0, merr = 0, mcnt = 0, midx = 0;
  bit live = 0, done = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mread(int off);
    if (off == 3) return (mpend << 7) | 1;
    if (off == 7) return mregs[mptr];
    return 0;
  endfunction

  task automatic mupdate(bit wr, int off, int d);
    int p;
    if (off == 3 && wr) mptr = d % NR;
    if (off == 7 && !wr && mptr == 7) mpend = 0;
    if (off == 7 && wr) begin
      p = mptr;
      mregs[p] = d;
      mptr = (p + 1) % NR;
      if (p == 1 && (d & 8) != 0) mpend = 0;
      if (p == 8) begin
        if ((d & 'h7F) == 'h00) begin mpend = 1; mregs[7] = 'h01; end
        else if ((d & 'h7F) == 'h06) begin mpend = 1; mregs[7] = target_present ? 'h8A : 'h42; end
        else if ((d & 'h7F) == 'h20) begin
          mcnt = (mregs[12] << 16) | (mregs[13] << 8) | mregs[14];
          midx = 0; mpend = 0;
        end
      end
      if (p == 9) begin
        if ((mregs[8] & 'h7F) == 'h20 && midx < mcnt) begin
          midx++;
          if (midx == mcnt) begin mpend = 1; mregs[7] = dir_out ? 'h18 : 'h19; end
        end else merr = 1;
      end
    end
  endtask

  task automatic acc(bit wr, int off, int d, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_off = off[2:0]; bus_wdata = d[7:0];
    #1;
    if (!wr) chk(tag, bus_rdata, mread(off));
    @(posedge clk);
    mupdate(wr, off, d);
    #1 bus_sel = 0;
  endtask

  task automatic wreg(int idx, int d);
    acc(1, 3, idx, "");
    acc(1, 7, d, "");
  endtask

  always @(negedge clk) if (live) begin
    chk("R11 irq level vs pending", irq, mpend);
    chk("R10 sticky xfer_err", xfer_err, merr);
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) mregs[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    live = 1;
    chk("R11 irq after reset", irq, 0);
    chk("R11 xfer_err after reset", xfer_err, 0);
    acc(0, 3, 0, "R3 idle status byte");
    acc(0, 7, 0, "R11 register 0 after reset");
    acc(1, 3, 'h25, "");
    acc(1, 7, 'hA5, "");
    acc(1, 3, 5, "");
    acc(0, 7, 0, "R2 masked pointer store");
    acc(0, 7, 0, "R4 read keeps pointer");
    acc(1, 3, 31, "");
    acc(1, 7, 'h3C, "");
    acc(0, 7, 0, "R4 pointer wraps to 0");
    acc(1, 3, 31, "");
    acc(0, 7, 0, "R4 last register stored");
    acc(1, 0, 'hFF, "");
    acc(1, 5, 'hFF, "");
    acc(0, 1, 0, "R1 unused offset reads zero");
    acc(0, 7, 0, "R1 pointer untouched by unused offset");
    wreg(8, 'h80);
    acc(0, 3, 0, "R6 status shows irq after reset command");
    acc(1, 3, 7, "");
    acc(0, 7, 0, "R6 csr reset code / R5 read clears");
    acc(0, 3, 0, "R5 status after csr read");
    wreg(9, 'h11);
    chk("R10 idle data write flags error", xfer_err, 1);
    target_present = 0;
    wreg(8, 'h06);
    acc(1, 3, 7, "");
    acc(1, 3, 1, "");
    acc(1, 7, 'h08, "");
    chk("R5 control clear bit drops irq", irq, 0);
    acc(1, 3, 7, "");
    acc(0, 7, 0, "R7 selection timeout code");
    target_present = 1;
    wreg(8, 'h06);
    acc(1, 3, 7, "");
    acc(0, 7, 0, "R7 command phase code");
    wreg(8, 'h06);
    acc(1, 3, 12, "");
    acc(1, 7, 0, ""); acc(1, 7, 0, ""); acc(1, 7, 3, "");
    wreg(8, 'h20);
    chk("R8 transfer command clears irq", irq, 0);
    dir_out = 1;
    for (int k = 0; k < 3; k++) wreg(9, k);
    chk("R9 irq after last byte", irq, 1);
    acc(1, 3, 7, "");
    acc(0, 7, 0, "R9 data-out done code");
    wreg(9, 'h55);
    chk("R10 overrun leaves irq low", irq, 0);
    acc(1, 3, 7, "");
    acc(0, 7, 0, "R10 overrun keeps csr");
    acc(1, 3, 12, "");
    acc(1, 7, 0, ""); acc(1, 7, 1, ""); acc(1, 7, 0, "");
    wreg(8, 'hA0);
    dir_out = 0;
    for (int k = 0; k < 255; k++) wreg(9, k);
    chk("R9 no irq before count reached", irq, 0);
    wreg(9, 'hEE);
    chk("R9 irq at 256th byte", irq, 1);
    acc(1, 3, 7, "");
    acc(0, 7, 0, "R9 data-in done code");
    acc(0, 3, 0, "R3 status after clear");
    repeat (2) @(posedge clk);
    done = 1;
    summary();
  end
endmodule